// File: doc/BRIEF.md
# Program Status Word Unit with Per-Mode Save Slots

This block holds the processor's current status word: four condition flags, two interrupt-mask bits and a five-bit operating-mode field. An ALU result updates the flags through a strobe. An explicit write can replace the whole word.

When an exception is taken, the block copies the live status word into a save slot that belongs to the target mode. It then switches the mode field to that mode and raises the interrupt masks. When an exception return is requested, the block reinstates the status word from the slot of the mode that is active at that time. Each of the five exception modes owns one slot. User and system modes own no slot.

The live word and the active mode's saved copy are both visible at the ports. The core pipeline can therefore read them directly. Vector generation, the ALU itself and the banked general registers live elsewhere.

Top module: `status_word_unit`

## Requirements
- R1: After reset, the status word is 0x0000_00D3: flags clear, both masks set, and mode code 5'b10011 (supervisor). The saved-copy output reads 0.
- R2: On a flag update, bit 31 (N) takes result bit 31, and bit 30 (Z) is set exactly when the result is all zeros.
- R3: On a flag update, bit 29 (C) takes the ALU carry-out for every operation kind. The operation kind is 2'b00 for logic, 2'b01 for add, and 2'b10 or 2'b11 for subtract. Bit 28 (V) behaves as follows:
  - add: V is set when both operands share a sign that the result lacks.
  - subtract: V is set when the operand signs differ and the result sign differs from operand A.
  - logic: V is left unchanged.
- R4: A flag update changes only bits 31:28. Bits 7:0, which hold the masks and the mode, are unchanged.
- R5: On an exception entry to a valid exception mode, the following happens in one cycle:
  - the slot of the target mode receives the pre-entry status word;
  - the mode field (bits 4:0) takes the target code;
  - bit 7 (IRQ mask) is set;
  - the flags are kept.
  The valid exception mode codes are FIQ 5'b10001, IRQ 5'b10010, supervisor 5'b10011, abort 5'b10111 and undefined 5'b11011.
- R6: Entry to FIQ mode also sets bit 6 (FIQ mask). Entry to any other mode leaves bit 6 as it was.
- R7: An exception return in an exception mode restores the whole status word from that mode's slot. This supports nested entries unwinding in order.
- R8: An exception return in user mode (5'b10000) or system mode (5'b11111) leaves the status word unchanged.
- R9: When an exception entry and a flag update fall in the same cycle, the entry wins. The flags are not updated, and the slot receives the status word from before the update.
- R10: A full write stores the write data masked to bits 31:28, 7, 6 and 4:0. All other bits of the status word always read 0.
- R11: An exception-entry request whose target code is not one of the five exception modes is ignored. Any lower-priority request in the same cycle proceeds.
- R12: The saved-copy output shows the slot of the current mode, and reads 0 in user and system modes.
- R13: Requests are ranked in this order: entry, then return, then full write, then flag update. A return in user or system mode still outranks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_we_i | input | 1 | Flag update strobe |
| alu_op_i | input | 2 | Operation kind: 00 logic, 01 add, 1x subtract |
| alu_a_i | input | 32 | ALU operand A |
| alu_b_i | input | 32 | ALU operand B |
| alu_res_i | input | 32 | ALU result |
| alu_cout_i | input | 1 | ALU carry-out |
| exc_req_i | input | 1 | Exception entry request |
| exc_mode_i | input | 5 | Target mode code for entry |
| exc_ret_i | input | 1 | Exception return request |
| wr_en_i | input | 1 | Full status write enable |
| wr_data_i | input | 32 | Full status write data |
| status_o | output | 32 | Current status word |
| saved_o | output | 32 | Saved copy of the current mode |

## Verification
The critical coincidence is an exception entry landing in the same cycle as a flag-update strobe. The bench drives both on one edge: it sends a zero result that would set Z, together with an entry into supervisor mode.

It judges the result in two steps:
- It checks that the flags are unchanged and that the new slot holds the pre-update word.
- It then issues a return and checks that the restored word still carries the old flags.

The same approach covers the other pairings: entry with return, return with write, and write with flag update.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned NUM_SLOTS = 5;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);

  localparam int unsigned BIT_N  = 31;
  localparam int unsigned BIT_Z  = 30;
  localparam int unsigned BIT_C  = 29;
  localparam int unsigned BIT_V  = 28;
  localparam int unsigned BIT_IM = 7;
  localparam int unsigned BIT_FM = 6;

  localparam logic [WORD_W-1:0] DEF_MASK = 32'hF000_00DF;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [1:0] {
    OP_LOGIC = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_CMP   = 2'b11
  } alu_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [WORD_W-1:0] RESET_WORD =
    (WORD_W'(1) << BIT_IM) | (WORD_W'(1) << BIT_FM) | WORD_W'(MODE_SVC);
endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] res_i,
  input  logic         cout_i,
  input  flags_t       old_i,
  output flags_t       new_o
);
  localparam int unsigned MSB = W - 1;

  logic sa, sb, sr;
  logic v_add, v_sub;

  assign sa = a_i[MSB];
  assign sb = b_i[MSB];
  assign sr = res_i[MSB];

  assign v_add = (sa == sb) && (sr != sa);
  assign v_sub = (sa != sb) && (sr != sa);

  always_comb begin
    new_o.n = sr;
    new_o.z = (res_i == '0);
    new_o.c = cout_i;
    unique case (alu_kind_e'(op_i))
      OP_LOGIC: new_o.v = old_i.v;
      OP_ADD:   new_o.v = v_add;
      default:  new_o.v = v_sub;
    endcase
  end
endmodule

// File: rtl/psr_mode_dec.sv
module psr_mode_dec
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  always_comb begin
    slot_o  = '0;
    valid_o = 1'b1;
    unique case (mode_i)
      MODE_FIQ: slot_o = SLOT_W'(0);
      MODE_IRQ: slot_o = SLOT_W'(1);
      MODE_SVC: slot_o = SLOT_W'(2);
      MODE_ABT: slot_o = SLOT_W'(3);
      MODE_UND: slot_o = SLOT_W'(4);
      default:  valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_save_bank.sv
module psr_save_bank #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 5,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] slot_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (we_i && (wr_idx_i == IW'(g))) begin
        slot_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx_i == IW'(i)) rd_data_o = slot_q[i];
    end
  end
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
  import psr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_we_i,
  input  logic [1:0]        alu_op_i,
  input  logic [WORD_W-1:0] alu_a_i,
  input  logic [WORD_W-1:0] alu_b_i,
  input  logic [WORD_W-1:0] alu_res_i,
  input  logic              alu_cout_i,
  input  logic              exc_req_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic              exc_ret_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] saved_o
);
  logic [WORD_W-1:0] stat_q, stat_d;
  logic [WORD_W-1:0] slot_rd;
  logic [SLOT_W-1:0] tgt_slot, cur_slot;
  logic              tgt_valid, cur_valid;
  logic              save_we, entry_go;
  flags_t            flags_old, flags_new;

  assign flags_old = {stat_q[BIT_N], stat_q[BIT_Z], stat_q[BIT_C], stat_q[BIT_V]};

  psr_flag_calc #(.W(WORD_W)) u_flag (
    .op_i   (alu_op_i),
    .a_i    (alu_a_i),
    .b_i    (alu_b_i),
    .res_i  (alu_res_i),
    .cout_i (alu_cout_i),
    .old_i  (flags_old),
    .new_o  (flags_new)
  );

  psr_mode_dec u_tgt_dec (
    .mode_i  (exc_mode_i),
    .slot_o  (tgt_slot),
    .valid_o (tgt_valid)
  );

  psr_mode_dec u_cur_dec (
    .mode_i  (stat_q[MODE_W-1:0]),
    .slot_o  (cur_slot),
    .valid_o (cur_valid)
  );

  assign entry_go = exc_req_i && tgt_valid;
  assign save_we  = entry_go;

  psr_save_bank #(.W(WORD_W), .N(NUM_SLOTS), .IW(SLOT_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (save_we),
    .wr_idx_i  (tgt_slot),
    .wr_data_i (stat_q),
    .rd_idx_i  (cur_slot),
    .rd_data_o (slot_rd)
  );

  // priority: entry > return > full write > flag update
  always_comb begin
    stat_d = stat_q;
    if (entry_go) begin
      stat_d[MODE_W-1:0] = exc_mode_i;
      stat_d[BIT_IM]     = 1'b1;
      if (exc_mode_i == MODE_FIQ) stat_d[BIT_FM] = 1'b1;
    end else if (exc_ret_i) begin
      if (cur_valid) stat_d = slot_rd & DEF_MASK;
    end else if (wr_en_i) begin
      stat_d = wr_data_i & DEF_MASK;
    end else if (flag_we_i) begin
      stat_d[BIT_N] = flags_new.n;
      stat_d[BIT_Z] = flags_new.z;
      stat_d[BIT_C] = flags_new.c;
      stat_d[BIT_V] = flags_new.v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= RESET_WORD;
    else         stat_q <= stat_d;
  end

  assign status_o = stat_q;
  assign saved_o  = cur_valid ? slot_rd : '0;

  p_flag_keeps_ctrl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !exc_req_i && !exc_ret_i && !wr_en_i) |=> status_o[7:0] == $past(status_o[7:0]));

  p_entry_mode_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_go |=> status_o[BIT_IM] && (status_o[MODE_W-1:0] == $past(exc_mode_i)));

  p_fiq_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && exc_mode_i == MODE_FIQ) |=> status_o[BIT_FM]);

  p_return_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_ret_i && !cur_valid && !entry_go) |=> $stable(status_o));

  p_entry_saves_pre_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_go |=> saved_o == $past(status_o));

  p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~DEF_MASK) == '0);

  p_user_no_copy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[MODE_W-1:0] == MODE_USR || status_o[MODE_W-1:0] == MODE_SYS) |-> saved_o == '0);
endmodule

// File: tb/status_word_unit_bench.sv
`timescale 1ns/1ps
module status_word_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flag_we_i = 1'b0;
  logic [1:0]  alu_op_i = 2'b00;
  logic [31:0] alu_a_i = '0, alu_b_i = '0, alu_res_i = '0;
  logic        alu_cout_i = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [4:0]  exc_mode_i = 5'b10000;
  logic        exc_ret_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] status_o, saved_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  status_word_unit u_status_word_unit (
    .clk_i, .rst_ni, .flag_we_i, .alu_op_i, .alu_a_i, .alu_b_i, .alu_res_i,
    .alu_cout_i, .exc_req_i, .exc_mode_i, .exc_ret_i, .wr_en_i, .wr_data_i,
    .status_o, .saved_o
  );

  task automatic check(input logic [31:0] exp_s, input logic [31:0] exp_v, input string req);
    n_chk++;
    if (status_o !== exp_s || saved_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s: status=%h saved=%h expected status=%h saved=%h",
               req, status_o, saved_o, exp_s, exp_v);
    end
  endtask

  task automatic idle();
    flag_we_i = 0; exc_req_i = 0; exc_ret_i = 0; wr_en_i = 0;
  endtask

  // apply current inputs for one edge, then clear and settle at negedge
  task automatic step();
    @(negedge clk_i);
    idle();
  endtask

  task automatic flag(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] r, input logic c);
    alu_op_i = op; alu_a_i = a; alu_b_i = b; alu_res_i = r; alu_cout_i = c; flag_we_i = 1;
  endtask

  task automatic t_reset();
    check(32'h0000_00D3, 32'h0, "R1 reset");
  endtask

  task automatic t_write();
    wr_en_i = 1; wr_data_i = 32'hFFFF_FFFF; step();
    check(32'hF000_00DF, 32'h0, "R10 masked write");
    wr_en_i = 1; wr_data_i = 32'h0000_0010; step();
    check(32'h0000_0010, 32'h0, "R10 write user");
  endtask

  task automatic t_flags();
    flag(2'b00, 0, 0, 32'h0000_0000, 1'b0); step();
    check(32'h4000_0010, 32'h0, "R2 zero");
    flag(2'b00, 0, 0, 32'h8000_0000, 1'b1); step();
    check(32'hA000_0010, 32'h0, "R2 negative carry");
    flag(2'b01, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0); step();
    check(32'h9000_0010, 32'h0, "R3 add overflow pos");
    flag(2'b01, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b1); step();
    check(32'h7000_0010, 32'h0, "R3 add overflow neg");
    flag(2'b10, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b1); step();
    check(32'h3000_0010, 32'h0, "R3 sub overflow");
    flag(2'b00, 0, 0, 32'h1, 1'b0); step();
    check(32'h1000_0010, 32'h0, "R3 logic keeps V / R4 ctrl kept");
  endtask

  task automatic t_user_return();
    exc_ret_i = 1; step();
    check(32'h1000_0010, 32'h0, "R8 return in user");
  endtask

  task automatic t_nested();
    exc_req_i = 1; exc_mode_i = 5'b10010; step();
    check(32'h1000_0092, 32'h1000_0010, "R5 irq entry");
    exc_req_i = 1; exc_mode_i = 5'b10001; step();
    check(32'h1000_00D1, 32'h1000_0092, "R6 fiq entry");
    exc_ret_i = 1; step();
    check(32'h1000_0092, 32'h1000_0010, "R7 return fiq");
    exc_ret_i = 1; step();
    check(32'h1000_0010, 32'h0, "R7 return irq / R12");
  endtask

  task automatic t_coincide();
    flag(2'b00, 0, 0, 32'h0, 1'b0);
    exc_req_i = 1; exc_mode_i = 5'b10011; step();
    check(32'h1000_0093, 32'h1000_0010, "R9 entry beats flags");
    exc_ret_i = 1; step();
    check(32'h1000_0010, 32'h0, "R9 restored old flags");
  endtask

  task automatic t_bad_target();
    exc_req_i = 1; exc_mode_i = 5'b10000; step();
    check(32'h1000_0010, 32'h0, "R11 user target ignored");
    exc_req_i = 1; exc_mode_i = 5'b11111; wr_en_i = 1; wr_data_i = 32'h2000_0010; step();
    check(32'h2000_0010, 32'h0, "R11 ignored entry lets write through");
  endtask

  task automatic t_priority();
    exc_req_i = 1; exc_mode_i = 5'b11011; step();
    check(32'h2000_009B, 32'h2000_0010, "R5 und entry");
    exc_ret_i = 1; wr_en_i = 1; wr_data_i = 32'h0000_001F; step();
    check(32'h2000_0010, 32'h0, "R13 return beats write");
    wr_en_i = 1; wr_data_i = 32'h0000_001F; flag(2'b00, 0, 0, 32'h0, 1'b1); step();
    check(32'h0000_001F, 32'h0, "R13 write beats flags");
    exc_ret_i = 1; wr_en_i = 1; wr_data_i = 32'h0000_0010; step();
    check(32'h0000_001F, 32'h0, "R13 system return beats write / R8");
    exc_req_i = 1; exc_mode_i = 5'b10111; step();
    check(32'h0000_0097, 32'h0000_001F, "R6 abort keeps F");
    exc_req_i = 1; exc_mode_i = 5'b10010; exc_ret_i = 1; step();
    check(32'h0000_0092, 32'h0000_0097, "R13 entry beats return");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write();
    t_flags();
    t_user_return();
    t_nested();
    t_coincide();
    t_bad_target();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule